// File: doc/BRIEF.md
# Pattern-addressed gather rank

This block models one memory rank built from eight word-wide chip memories that share a single command path. Every stored line is permuted on its way in: logical word `l` of a line at column `X` is placed in chip `l XOR X[2:0]`. On every access, each chip forms its own local column from the requested column, the pattern code and its own chip index. This lets one access return a normal line, or a strided gather that holds the same logical word from eight neighbouring lines.

A read carries a column and a 3-bit pattern code. Pattern 0 returns the line stored at that column. Take pattern 7 with the column set to an 8-aligned base plus `i`. The read then returns logical word `i` of each of the eight lines in that aligned group, in line order. Writes use the same per-chip columns, so a write with a nonzero pattern scatters its eight words to the locations that the matching gather reads.

Both ports use valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. Read data appears on the response port one cycle after acceptance. It stays there, unchanged, until `rsp_ready` is high. While a response is stalled, `req_ready` is low, so at most one response is ever outstanding. A response handoff and a new request can complete on the same edge. Writes produce no response.

Top module: `gather_rank`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0. With no response pending, `req_ready` is 1.
- R2: For requested column X and pattern P, chip c uses local column X with its low 3 bits replaced by `(c AND P) XOR X[2:0]`. The upper column bits are unchanged. Chip 0 always uses X, and pattern 0 gives every chip column X.
- R3: On a write, the logical word `l` of `req_wdata` occupies bits `[64*l +: 64]`. It is stored in chip `l XOR X[2:0]` at that chip's R2 column.
- R4: On a read, output word `l` (`rsp_data[64*l +: 64]`) is taken from chip `l XOR X[2:0]`. A pattern-0 read of a column written with pattern 0 returns the written line unchanged.
- R5: With pattern 7 and column X = B + i, where B is a multiple of 8 and i < 8, output word `l` is logical word `i` of the line at column `B + l`. This assumes all those lines were written with pattern 0.
- R6: For every pattern and for both aligned and unaligned columns, each output word equals the logical word that R2–R4 locate in a flat array of stored lines.
- R7: A write with pattern P at column X, followed by a read with the same P and X, returns the written data. Other lines change only in the words the scatter overwrote.
- R8: A read accepted on one edge makes `rsp_valid` high from that edge until its handoff.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds steady, `rsp_valid` stays high and `req_ready` is low.
- R10: An accepted write does not raise `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_col | input | 6 | Requested column |
| req_pat | input | 3 | Pattern code |
| req_wdata | input | 512 | Write line, word l in bits [64*l +: 64] |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 512 | Gathered line, word l in bits [64*l +: 64] |

## Verification
A response handoff and the acceptance of the next request can fall on the same edge. The bench provokes this by driving a second read while the first response is still valid with `rsp_ready` high. It then judges that the second response appears one cycle later with the second gather's data. The second case is a stall: a request is held against a response with `rsp_ready` low. The bench checks that `req_ready` stays low and the stalled data holds. When `rsp_ready` rises, both transfers must complete together. Every gathered word is compared with a flat reference array of logical words, before and after scatter writes.

// File: rtl/gr_pkg.sv
package gr_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } gr_op_e;
endpackage

// File: rtl/gr_butterfly.sv
// XOR permutation network: dout word g = din word (g ^ key).
// Built from log2(N) conditional group-swap stages; self-inverse.
module gr_butterfly #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 64,
  localparam int SEL_W    = $clog2(NUM_WORDS),
  localparam int LINE_W   = NUM_WORDS * WORD_W
) (
  input  logic [SEL_W-1:0]  key,
  input  logic [LINE_W-1:0] din,
  output logic [LINE_W-1:0] dout
);
  logic [LINE_W-1:0] stage [SEL_W+1];

  assign stage[0] = din;

  for (genvar j = 0; j < SEL_W; j++) begin : g_stage
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      assign stage[j+1][g*WORD_W +: WORD_W] = key[j]
        ? stage[j][(g ^ (1 << j))*WORD_W +: WORD_W]
        : stage[j][g*WORD_W +: WORD_W];
    end
  end

  assign dout = stage[SEL_W];
endmodule

// File: rtl/gr_chip.sv
// One word-wide chip memory with its private column decode.
module gr_chip #(
  parameter int CHIP_ID = 0,
  parameter int WORD_W  = 64,
  parameter int DEPTH   = 64,
  parameter int SEL_W   = 3,
  localparam int COL_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [COL_W-1:0]  col,
  input  logic [SEL_W-1:0]  pat,
  input  logic [WORD_W-1:0] wdata,
  output logic [COL_W-1:0]  chip_col,
  output logic [WORD_W-1:0] rdata
);
  localparam logic [SEL_W-1:0] ID_BITS = SEL_W'(CHIP_ID);

  logic [WORD_W-1:0] mem [DEPTH];

  assign chip_col = {col[COL_W-1:SEL_W], col[SEL_W-1:0] ^ (ID_BITS & pat)};

  always_ff @(posedge clk) begin
    if (en && we) begin
      mem[chip_col] <= wdata;
    end
    if (en && !we) begin
      rdata <= mem[chip_col];
    end
  end
endmodule

// File: rtl/gather_rank.sv
module gather_rank #(
  parameter int NUM_CHIPS = 8,
  parameter int WORD_W    = 64,
  parameter int DEPTH     = 64,
  localparam int SEL_W    = $clog2(NUM_CHIPS),
  localparam int COL_W    = $clog2(DEPTH),
  localparam int LINE_W   = NUM_CHIPS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [COL_W-1:0]  req_col,
  input  logic [SEL_W-1:0]  req_pat,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LINE_W-1:0] rsp_data
);
  import gr_pkg::*;

  gr_op_e            op;
  logic              fire;
  logic [LINE_W-1:0] wr_phys;
  logic [LINE_W-1:0] rd_phys;
  logic [SEL_W-1:0]  key_q;
  logic [COL_W-1:0]  chip_col [NUM_CHIPS];

  assign op        = req_write ? OP_WRITE : OP_READ;
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  // Store side: logical word l goes to chip l ^ key.
  gr_butterfly #(.NUM_WORDS(NUM_CHIPS), .WORD_W(WORD_W)) u_wr_shuf (
    .key  (req_col[SEL_W-1:0]),
    .din  (req_wdata),
    .dout (wr_phys)
  );

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    gr_chip #(
      .CHIP_ID (c),
      .WORD_W  (WORD_W),
      .DEPTH   (DEPTH),
      .SEL_W   (SEL_W)
    ) u_chip (
      .clk      (clk),
      .en       (fire),
      .we       (op == OP_WRITE),
      .col      (req_col),
      .pat      (req_pat),
      .wdata    (wr_phys[c*WORD_W +: WORD_W]),
      .chip_col (chip_col[c]),
      .rdata    (rd_phys[c*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      key_q     <= '0;
    end else if (fire && op == OP_READ) begin
      rsp_valid <= 1'b1;
      key_q     <= req_col[SEL_W-1:0];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // Return side: output word l comes from chip l ^ key.
  gr_butterfly #(.NUM_WORDS(NUM_CHIPS), .WORD_W(WORD_W)) u_rd_shuf (
    .key  (key_q),
    .din  (rd_phys),
    .dout (rsp_data)
  );

  // R2
  chip0_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> chip_col[0] == req_col);

  // R2
  base_mode_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_pat == '0) |-> chip_col[NUM_CHIPS-1] == req_col);

  // R2
  upper_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> chip_col[NUM_CHIPS-1][COL_W-1:SEL_W] == req_col[COL_W-1:SEL_W]);

  // R8
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write) |=> rsp_valid);

  // R10
  write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write) |=> !rsp_valid);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: tb/test_gather_rank.sv
module test_gather_rank;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int WW = 64;
  localparam int DP = 64;
  localparam int LW = NW * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [5:0]    req_col = '0;
  logic [2:0]    req_pat = '0;
  logic [LW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [LW-1:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [WW-1:0] refm [DP][NW];

  // {column, pattern} stimulus table; expected data comes from the reference array
  localparam logic [8:0] VEC [12] = '{
    {6'd0, 3'd0},  {6'd8, 3'd7},  {6'd9, 3'd7},  {6'd15, 3'd7},
    {6'd3, 3'd1},  {6'd12, 3'd2}, {6'd21, 3'd3}, {6'd33, 3'd4},
    {6'd46, 3'd5}, {6'd55, 3'd6}, {6'd63, 3'd7}, {6'd58, 3'd0}
  };

  gather_rank i_gather_rank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_col(req_col), .req_pat(req_pat), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WW-1:0] gen(input int line, input int w);
    return {32'(line) * 32'h9E3779B1, 8'(w), 24'(line)};
  endfunction

  function automatic logic [5:0] pcol(input logic [5:0] col, input logic [2:0] pat, input int c);
    return {col[5:3], (3'(c) & pat) ^ col[2:0]};
  endfunction

  function automatic logic [LW-1:0] exp_read(input logic [5:0] col, input logic [2:0] pat);
    logic [LW-1:0] r;
    for (int l = 0; l < NW; l++) begin
      int c;
      logic [5:0] pc;
      c = l ^ int'(col[2:0]);
      pc = pcol(col, pat, c);
      r[l*WW +: WW] = refm[pc][c ^ int'(pc[2:0])];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at a falling edge.
  task automatic do_write(input logic [5:0] col, input logic [2:0] pat, input logic [LW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_col = col; req_pat = pat; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    for (int l = 0; l < NW; l++) begin
      int c;
      logic [5:0] pc;
      c = l ^ int'(col[2:0]);
      pc = pcol(col, pat, c);
      refm[pc][c ^ int'(pc[2:0])] = d[l*WW +: WW];
    end
  endtask

  task automatic do_read(input logic [5:0] col, input logic [2:0] pat, input string tag,
                         output logic [LW-1:0] got);
    req_valid = 1'b1; req_write = 1'b0; req_col = col; req_pat = pat;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, LW'(rsp_valid), LW'(1));
    got = rsp_data;
    chk(tag, rsp_data, exp_read(col, pat));
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [LW-1:0] got;
    logic [LW-1:0] exp;
    logic [LW-1:0] d2;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 rsp_valid in reset", LW'(rsp_valid), LW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", LW'(rsp_valid), LW'(0));
    chk("R1 req_ready idle", LW'(req_ready), LW'(1));

    for (int ln = 0; ln < DP; ln++) begin
      logic [LW-1:0] d;
      for (int w = 0; w < NW; w++) d[w*WW +: WW] = gen(ln, w);
      do_write(6'(ln), 3'd0, d);
      if (ln == 9) chk("R10 no response after write", LW'(rsp_valid), LW'(0));
    end

    // R4: pattern 0 returns the line unchanged
    do_read(6'd5, 3'd0, "R4 base read", got);
    for (int w = 0; w < NW; w++) exp[w*WW +: WW] = gen(5, w);
    chk("R4 base line equals written", got, exp);

    // R5: pattern 7 with column 8+3 gathers word 3 of lines 8..15
    do_read(6'd11, 3'd7, "R5 gather", got);
    for (int l = 0; l < NW; l++) exp[l*WW +: WW] = gen(8 + l, 3);
    chk("R5 word 3 of group", got, exp);
    do_read(6'd40, 3'd7, "R5 gather", got);
    for (int l = 0; l < NW; l++) exp[l*WW +: WW] = gen(40 + l, 0);
    chk("R5 word 0 of group", got, exp);

    // R3: aligned pattern 7 read exposes chip c raw; line 9 word 0 sits in chip 1
    do_read(6'd8, 3'd7, "R3 raw", got);
    chk("R3 shuffle placement", LW'(got[1*WW +: WW]), LW'(gen(9, 0)));

    // R6 / R2: table walk
    for (int i = 0; i < 12; i++) do_read(VEC[i][8:3], VEC[i][2:0], "R6 table", got);
    for (int p = 0; p < 8; p++) begin
      do_read(6'd24, 3'(p), "R2 aligned", got);
      do_read(6'd29, 3'(p), "R2 unaligned", got);
    end

    // R7: scatter then gather with the same pattern
    for (int w = 0; w < NW; w++) d2[w*WW +: WW] = {32'hC0DE0000 | 32'(w), 32'h5CA77E12};
    do_write(6'd18, 3'd5, d2);
    do_read(6'd18, 3'd5, "R7 scatter readback", got);
    chk("R7 data returned", got, d2);
    for (int ln = 16; ln < 24; ln++) do_read(6'(ln), 3'd0, "R7 neighbours", got);

    // Same-edge handoff and accept
    req_valid = 1'b1; req_write = 1'b0; req_col = 6'd19; req_pat = 3'd7;
    @(posedge clk); @(negedge clk);
    chk("R8 first rsp", rsp_data, exp_read(6'd19, 3'd7));
    req_col = 6'd44; req_pat = 3'd3;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second rsp valid", LW'(rsp_valid), LW'(1));
    chk("R8 second rsp", rsp_data, exp_read(6'd44, 3'd3));
    @(posedge clk); @(negedge clk);
    chk("R8 drained", LW'(rsp_valid), LW'(0));

    // R9: back-pressure
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_col = 6'd2; req_pat = 3'd6;
    @(posedge clk); @(negedge clk);
    exp = exp_read(6'd2, 3'd6);
    chk("R9 first rsp", rsp_data, exp);
    chk("R9 req_ready low", LW'(req_ready), LW'(0));
    req_col = 6'd50; req_pat = 3'd1;
    @(posedge clk); @(negedge clk);
    chk("R9 held valid", LW'(rsp_valid), LW'(1));
    chk("R9 held data", rsp_data, exp);
    chk("R9 still blocked", LW'(req_ready), LW'(0));
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk("R9 next valid", LW'(rsp_valid), LW'(1));
    chk("R9 next data", rsp_data, exp_read(6'd50, 3'd1));
    @(posedge clk); @(negedge clk);

    // R6: final sweep of every line after the scatter
    for (int ln = 0; ln < DP; ln++) do_read(6'(ln), 3'd0, "R6 final sweep", got);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule